// File: doc/BRIEF.md
# Memory Bank Range Decoder

This block keeps the start, end and enable configuration for eight DRAM banks. It turns that configuration into a 32-bit inclusive address window per bank, with 1 MB granularity. Every physical address presented to it is decoded, without a clock, into a vector that shows which enabled banks contain that address.

Configuration arrives over a single-cycle register write port. A combinational read port returns any register. Four 32-bit register kinds each exist in two sets: start, extended start, end and extended end. Banks 0-3 use set 0 and banks 4-7 use set 1. Each bank owns one byte lane of the registers in its set.

When the memory-go control bit changes from clear to set, a small state machine walks the banks one per clock. It adds up the sizes of the enabled banks and flags any bank that does not begin where the previous memory ended. The machine has three states:

- IDLE: waits for the go edge. IDLE goes to SCAN on a go edge and stays in IDLE otherwise.
- SCAN: handles bank `idx` each cycle. SCAN stays in SCAN while `idx` is below 7, and goes to DONE after bank 7.
- DONE: lasts one cycle and raises `walk_done`. DONE always returns to IDLE.

Top module: `membank_decoder`

## Requirements
- R1: After reset, every configuration register reads 0, `bank_hit` is 0, and `total_size`, `contig_err`, `walk_busy` and `walk_done` are all 0.
- R2: Register indices are as follows: 0/1 start set 0/1, 2/3 extended start set 0/1, 4/5 end set 0/1, 6/7 extended end set 0/1, 8 bank enable, 9 control (bit 0 is memory-go). A write is taken when `cfg_we` is high at a rising clock edge. Indices 0-7 read back the full written word. Bank enable keeps and returns only bits 7:0. Control keeps and returns only bit 0.
- R3: Bank b takes its fields from set b/4, in byte lane b mod 4. The 8-bit field is bits [8*(b%4)+7 : 8*(b%4)]. The 2-bit extended field is bits [8*(b%4)+1 : 8*(b%4)].
- R4: A bank's start is (extended start << 30) | (start field << 20). A bank's end is (extended end << 30) | (end field << 20) | 0xFFFFF.
- R5: `bank_hit[b]` is 1 exactly when bank-enable bit b is set and start ≤ `phys_addr` ≤ end, with both bounds inclusive. The decode is combinational.
- R6: A walk starts only on a write that changes memory-go from 0 to 1. Writing 1 while the bit is already 1, or writing 0, starts nothing.
- R7: The go write's clock edge is counted as edge 0. `walk_busy` is high after edges 1 through 8, and `walk_done` is a single-cycle pulse after edge 9.
- R8: When `walk_done` is high, `total_size` equals the sum, modulo 2^35, of (end − start + 1) over all enabled banks.
- R9: When `walk_done` is high, `contig_err` is 1 exactly when some enabled bank with index greater than 0 has a start that differs from the running total of the enabled banks below it.
- R10: `total_size` and `contig_err` keep their values until the next walk finishes. Register writes between walks do not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 4 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_idx` (combinational) |
| phys_addr | input | 32 | Physical address to decode |
| bank_hit | output | 8 | One bit per enabled bank whose window holds `phys_addr` |
| walk_busy | output | 1 | The walk is in SCAN |
| walk_done | output | 1 | Single-cycle pulse when a walk result becomes valid |
| total_size | output | 35 | Summed size of the enabled banks, in bytes |
| contig_err | output | 1 | Not-contiguous warning from the last walk |

## Verification
The walk assertions assume that no configuration register changes while SCAN is active. The start and end words are sampled bank by bank, so a write in the middle of a walk would mix old and new values. The stimulus therefore waits for `walk_done` before writing again. The go-edge and enable-keep assertions assume at most one write per cycle, which the single-port interface already guarantees. Random configurations come from a fixed seed and include inverted windows (end below start). The bench model uses the same modulo-2^35 arithmetic, so no constraint on ordering is needed.

// File: rtl/bankdec_pkg.sv
package bankdec_pkg;

    // Kinds of per-set range registers; a register index is kind * sets + set.
    typedef enum logic [1:0] {
        RK_START  = 2'd0,
        RK_XSTART = 2'd1,
        RK_END    = 2'd2,
        RK_XEND   = 2'd3
    } range_kind_e;

    localparam int RANGE_KINDS = 4;

    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_SCAN = 2'd1,
        WS_DONE = 2'd2
    } walk_state_e;

endpackage

// File: rtl/bankdec_regs.sv
module bankdec_regs
    import bankdec_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int REG_W     = 32,
    parameter int FIELD_W   = 8,
    parameter int IDX_W     = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                we,
    input  logic [IDX_W-1:0]                    idx,
    input  logic [REG_W-1:0]                    wdata,
    output logic [REG_W-1:0]                    rdata,
    output logic [RANGE_KINDS-1:0][NUM_BANKS/(REG_W/FIELD_W)-1:0][REG_W-1:0] fields,
    output logic [NUM_BANKS-1:0]                bank_en,
    output logic                                go_start
);
    localparam int LANES    = REG_W / FIELD_W;
    localparam int NUM_SETS = NUM_BANKS / LANES;
    localparam int EN_IDX   = RANGE_KINDS * NUM_SETS;
    localparam int CTRL_IDX = EN_IDX + 1;

    logic go_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fields   <= '0;
            bank_en  <= '0;
            go_q     <= 1'b0;
            go_start <= 1'b0;
        end else begin
            go_start <= 1'b0;
            if (we) begin
                for (int k = 0; k < RANGE_KINDS; k++) begin
                    for (int s = 0; s < NUM_SETS; s++) begin
                        if (idx == IDX_W'(k * NUM_SETS + s)) begin
                            fields[k][s] <= wdata;
                        end
                    end
                end
                if (idx == IDX_W'(EN_IDX)) begin
                    bank_en <= wdata[NUM_BANKS-1:0];
                end
                if (idx == IDX_W'(CTRL_IDX)) begin
                    go_q     <= wdata[0];
                    go_start <= wdata[0] & ~go_q;
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < RANGE_KINDS; k++) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                if (idx == IDX_W'(k * NUM_SETS + s)) begin
                    rdata = fields[k][s];
                end
            end
        end
        if (idx == IDX_W'(EN_IDX)) begin
            rdata = REG_W'(bank_en);
        end
        if (idx == IDX_W'(CTRL_IDX)) begin
            rdata = REG_W'(go_q);
        end
    end

    // R6: a start request follows only a 0 -> 1 change of the go bit
    p_go_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        go_start |-> (go_q && !$past(go_q)));

    // R2: the enable register takes the low bits of the write word
    p_en_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && idx == IDX_W'(EN_IDX)) |=> (bank_en == $past(wdata[NUM_BANKS-1:0])));

endmodule

// File: rtl/bankdec_range.sv
module bankdec_range
    import bankdec_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int REG_W     = 32,
    parameter int FIELD_W   = 8,
    parameter int XFIELD_W  = 2,
    parameter int ADDR_W    = 32,
    parameter int GRAN_LOG2 = 20
) (
    input  logic [RANGE_KINDS-1:0][NUM_BANKS/(REG_W/FIELD_W)-1:0][REG_W-1:0] fields,
    output logic [NUM_BANKS-1:0][ADDR_W-1:0] bank_start,
    output logic [NUM_BANKS-1:0][ADDR_W-1:0] bank_end
);
    localparam int LANES = REG_W / FIELD_W;
    localparam int PAD_W = ADDR_W - XFIELD_W - FIELD_W - GRAN_LOG2;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int SET  = b / LANES;
        localparam int LANE = b % LANES;

        logic [FIELD_W-1:0]  lo_s, lo_e;
        logic [XFIELD_W-1:0] hi_s, hi_e;

        assign lo_s = fields[RK_START][SET][LANE*FIELD_W +: FIELD_W];
        assign lo_e = fields[RK_END][SET][LANE*FIELD_W +: FIELD_W];
        assign hi_s = fields[RK_XSTART][SET][LANE*FIELD_W +: XFIELD_W];
        assign hi_e = fields[RK_XEND][SET][LANE*FIELD_W +: XFIELD_W];

        if (PAD_W > 0) begin : g_pad
            assign bank_start[b] = {hi_s, {PAD_W{1'b0}}, lo_s, {GRAN_LOG2{1'b0}}};
            assign bank_end[b]   = {hi_e, {PAD_W{1'b0}}, lo_e, {GRAN_LOG2{1'b1}}};
        end else begin : g_nopad
            assign bank_start[b] = {hi_s, lo_s, {GRAN_LOG2{1'b0}}};
            assign bank_end[b]   = {hi_e, lo_e, {GRAN_LOG2{1'b1}}};
        end
    end

    // Extended registers use only two bits per byte lane.
    logic unused_ext_bits;
    assign unused_ext_bits = ^{fields[RK_XSTART], fields[RK_XEND]};

endmodule

// File: rtl/bankdec_hit.sv
module bankdec_hit #(
    parameter int NUM_BANKS = 8,
    parameter int ADDR_W    = 32
) (
    input  logic [ADDR_W-1:0]                addr,
    input  logic [NUM_BANKS-1:0]             bank_en,
    input  logic [NUM_BANKS-1:0][ADDR_W-1:0] bank_start,
    input  logic [NUM_BANKS-1:0][ADDR_W-1:0] bank_end,
    output logic [NUM_BANKS-1:0]             hit
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cmp
        logic ge_lo, le_hi;
        assign ge_lo  = (addr >= bank_start[b]);
        assign le_hi  = (addr <= bank_end[b]);
        assign hit[b] = bank_en[b] & ge_lo & le_hi;
    end
endmodule

// File: rtl/bankdec_walk.sv
module bankdec_walk
    import bankdec_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ADDR_W    = 32,
    parameter int SIZE_W    = ADDR_W + 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             go_start,
    input  logic [NUM_BANKS-1:0]             bank_en,
    input  logic [NUM_BANKS-1:0][ADDR_W-1:0] bank_start,
    input  logic [NUM_BANKS-1:0][ADDR_W-1:0] bank_end,
    output logic                             busy,
    output logic                             done,
    output logic [SIZE_W-1:0]                total,
    output logic                             warn
);
    localparam int IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_BANKS - 1);

    walk_state_e state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [SIZE_W-1:0] acc_q, acc_d;
    logic              gap_q, gap_d;
    logic [SIZE_W-1:0] total_q;
    logic              warn_q;

    logic [SIZE_W-1:0] cur_start, cur_size;
    logic              cur_en, cur_gap;

    assign cur_en    = bank_en[idx_q];
    assign cur_start = SIZE_W'(bank_start[idx_q]);
    assign cur_size  = SIZE_W'(bank_end[idx_q]) - cur_start + SIZE_W'(1);
    assign cur_gap   = cur_en && (idx_q != '0) && (cur_start != acc_q);
    assign acc_d     = cur_en ? (acc_q + cur_size) : acc_q;
    assign gap_d     = gap_q | cur_gap;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE: if (go_start) state_d = WS_SCAN;
            WS_SCAN: if (idx_q == LAST) state_d = WS_DONE;
            WS_DONE: state_d = WS_IDLE;
            default: state_d = WS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WS_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            acc_q   <= '0;
            gap_q   <= 1'b0;
            total_q <= '0;
            warn_q  <= 1'b0;
        end else begin
            unique case (state_q)
                WS_IDLE: begin
                    if (go_start) begin
                        idx_q <= '0;
                        acc_q <= '0;
                        gap_q <= 1'b0;
                    end
                end
                WS_SCAN: begin
                    idx_q <= idx_q + IDX_W'(1);
                    acc_q <= acc_d;
                    gap_q <= gap_d;
                    if (idx_q == LAST) begin
                        total_q <= acc_d;
                        warn_q  <= gap_d;
                    end
                end
                WS_DONE: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy  = (state_q == WS_SCAN);
        done  = (state_q == WS_DONE);
        total = total_q;
        warn  = warn_q;
    end

    // R7: done lasts exactly one cycle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: one bank per cycle while scanning
    p_scan_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WS_SCAN && idx_q != LAST) |=> (busy && idx_q == $past(idx_q) + IDX_W'(1)));

    // R7: the last bank is followed directly by the done pulse
    p_last_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WS_SCAN && idx_q == LAST) |=> done);

    // R10: results move only when the last bank is processed
    p_hold_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(state_q == WS_SCAN && idx_q == LAST) |=> ($stable(total_q) && $stable(warn_q)));

endmodule

// File: rtl/membank_decoder.sv
module membank_decoder
    import bankdec_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int REG_W     = 32,
    parameter int FIELD_W   = 8,
    parameter int XFIELD_W  = 2,
    parameter int ADDR_W    = 32,
    parameter int GRAN_LOG2 = 20,
    parameter int IDX_W     = 4,
    parameter int SIZE_W    = ADDR_W + 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic [REG_W-1:0]     cfg_wdata,
    output logic [REG_W-1:0]     cfg_rdata,
    input  logic [ADDR_W-1:0]    phys_addr,
    output logic [NUM_BANKS-1:0] bank_hit,
    output logic                 walk_busy,
    output logic                 walk_done,
    output logic [SIZE_W-1:0]    total_size,
    output logic                 contig_err
);
    localparam int LANES    = REG_W / FIELD_W;
    localparam int NUM_SETS = NUM_BANKS / LANES;

    logic [RANGE_KINDS-1:0][NUM_SETS-1:0][REG_W-1:0] fields;
    logic [NUM_BANKS-1:0]             bank_en;
    logic                             go_start;
    logic [NUM_BANKS-1:0][ADDR_W-1:0] bank_start, bank_end;

    bankdec_regs #(
        .NUM_BANKS(NUM_BANKS), .REG_W(REG_W), .FIELD_W(FIELD_W), .IDX_W(IDX_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx), .wdata(cfg_wdata),
        .rdata(cfg_rdata), .fields(fields), .bank_en(bank_en), .go_start(go_start)
    );

    bankdec_range #(
        .NUM_BANKS(NUM_BANKS), .REG_W(REG_W), .FIELD_W(FIELD_W),
        .XFIELD_W(XFIELD_W), .ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2)
    ) u_range (
        .fields(fields), .bank_start(bank_start), .bank_end(bank_end)
    );

    bankdec_hit #(
        .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)
    ) u_hit (
        .addr(phys_addr), .bank_en(bank_en), .bank_start(bank_start),
        .bank_end(bank_end), .hit(bank_hit)
    );

    bankdec_walk #(
        .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)
    ) u_walk (
        .clk(clk), .rst_n(rst_n), .go_start(go_start), .bank_en(bank_en),
        .bank_start(bank_start), .bank_end(bank_end), .busy(walk_busy),
        .done(walk_done), .total(total_size), .warn(contig_err)
    );

    // R5: a disabled bank never reports a hit
    p_hit_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_hit & ~bank_en) == '0);

    // R7: busy and done are never high together
    p_busy_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(walk_busy && walk_done));

endmodule

// File: tb/membank_decoder_tb.sv
module membank_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [31:0] phys_addr = '0;
    logic [7:0]  bank_hit;
    logic        walk_busy, walk_done;
    logic [34:0] total_size;
    logic        contig_err;

    int checks = 0;
    int failures = 0;
    logic [31:0] sh [10];

    membank_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .phys_addr(phys_addr),
        .bank_hit(bank_hit), .walk_busy(walk_busy), .walk_done(walk_done),
        .total_size(total_size), .contig_err(contig_err)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (idx < 8)       sh[idx] = d;
        else if (idx == 8) sh[8] = {24'h0, d[7:0]};
        else if (idx == 9) sh[9] = {31'h0, d[0]};
    endtask

    task automatic rd(input int idx, output logic [31:0] v);
        @(negedge clk);
        cfg_idx = 4'(idx);
        #1 v = cfg_rdata;
    endtask

    // R3/R4 model: set b/4, byte lane b%4
    function automatic logic [31:0] exp_start(input int b);
        int s = b / 4; int l = b % 4;
        return {sh[2+s][8*l +: 2], 2'b00, sh[0+s][8*l +: 8], 20'h0};
    endfunction

    function automatic logic [31:0] exp_end(input int b);
        int s = b / 4; int l = b % 4;
        return {sh[6+s][8*l +: 2], 2'b00, sh[4+s][8*l +: 8], 20'hFFFFF};
    endfunction

    function automatic logic [7:0] exp_hit(input logic [31:0] a);
        logic [7:0] h = '0;
        for (int b = 0; b < 8; b++)
            h[b] = sh[8][b] && (a >= exp_start(b)) && (a <= exp_end(b));
        return h;
    endfunction

    function automatic logic [35:0] exp_walk();  // {warn, total}
        logic [34:0] acc = '0;
        logic w = 1'b0;
        for (int b = 0; b < 8; b++) begin
            if (sh[8][b]) begin
                if (b != 0 && {3'b0, exp_start(b)} != acc) w = 1'b1;
                acc = acc + {3'b0, exp_end(b)} - {3'b0, exp_start(b)} + 35'd1;
            end
        end
        return {w, acc};
    endfunction

    task automatic hit_at(input logic [31:0] a, input string req);
        @(negedge clk);
        phys_addr = a;
        #1 chk(req, 64'(bank_hit), 64'(exp_hit(a)));
    endtask

    // Clears then sets go; checks timing (R7) and results (R8, R9).
    task automatic run_walk(input string tag);
        int n = 0;
        logic busy_ok = 1'b1;
        logic [35:0] e;
        wr(9, 32'h0);
        wr(9, 32'h1);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            n++;
            if (walk_done) break;
            if (!walk_busy) busy_ok = 1'b0;
        end
        e = exp_walk();
        chk({"R7 walk length ", tag}, 64'(n), 64'd9);
        chk({"R7 busy during scan ", tag}, 64'(busy_ok), 64'd1);
        chk({"R8 total size ", tag}, 64'(total_size), 64'(e[34:0]));
        chk({"R9 contiguity flag ", tag}, 64'(contig_err), 64'(e[35]));
        @(negedge clk);
        chk({"R7 done is one pulse ", tag}, 64'(walk_done), 64'd0);
    endtask

    task automatic quiet_window(input string req);
        logic seen = 1'b0;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (walk_done || walk_busy) seen = 1'b1;
        end
        chk(req, 64'(seen), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [34:0] held_t;
        logic held_w;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 10; i++) sh[i] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int i = 0; i < 10; i++) begin
            rd(i, v);
            chk("R1 register reset", 64'(v), 64'd0);
        end
        phys_addr = 32'h0; #1;
        chk("R1 hit reset", 64'(bank_hit), 64'd0);
        chk("R1 walk outputs reset",
            {28'h0, walk_busy, walk_done, contig_err, total_size}, 64'd0);

        // R2 register access
        for (int i = 0; i < 8; i++) begin
            logic [31:0] d = $urandom;
            wr(i, d);
            rd(i, v);
            chk("R2 range register readback", 64'(v), 64'(d));
        end
        wr(8, 32'hFFFF_FFFF);
        rd(8, v);
        chk("R2 enable keeps low 8 bits", 64'(v), 64'h0000_00FF);
        wr(9, 32'hFFFF_FFFE);
        rd(9, v);
        chk("R2 control keeps bit 0", 64'(v), 64'd0);

        // Directed contiguous layout: banks 0-3, 16 MB each
        wr(0, 32'h3020_1000); wr(2, 32'h0); wr(4, 32'h3F2F_1F0F); wr(6, 32'h0);
        wr(8, 32'h0F);
        hit_at(32'h0000_0000, "R5 first byte bank0");
        hit_at(32'h00FF_FFFF, "R5 last byte bank0");
        hit_at(32'h0100_0000, "R5 first byte bank1");
        hit_at(32'h0400_0000, "R5 past top");
        run_walk("contiguous");
        chk("R8 contiguous 64MB", 64'(total_size), 64'h0400_0000);
        chk("R9 contiguous no warn", 64'(contig_err), 64'd0);

        // Gap: bank1 starts at 17 MB
        wr(0, 32'h3020_1100);
        run_walk("gap");
        chk("R9 gap raises warn", 64'(contig_err), 64'd1);

        // Disabled bank0, bank1 at 0: index>0 but start equals running total 0
        wr(0, 32'h3020_0000); wr(8, 32'h02);
        run_walk("bank1 only");
        chk("R9 bank1 at zero no warn", 64'(contig_err), 64'd0);

        // Extended fields, upper set (R3, R4)
        wr(1, 32'h0000_AB00); wr(3, 32'h0000_0300); wr(5, 32'h0000_AC00); wr(7, 32'h0000_0300);
        wr(8, 32'h20);
        hit_at(32'hCAB0_0000, "R4 bank5 start with extended bits");
        hit_at(32'hCACF_FFFF, "R4 bank5 end with extended bits");
        hit_at(32'hCAAF_FFFF, "R4 bank5 below start");
        chk("R3 bank5 lane hit", 64'(bank_hit), 64'd0);

        // R6: re-writing 1 and writing 0 start nothing
        run_walk("before R6");
        wr(9, 32'h1);
        quiet_window("R6 rewrite of set go starts nothing");
        wr(9, 32'h0);
        quiet_window("R6 clearing go starts nothing");

        // R10: results held across configuration writes
        held_t = total_size; held_w = contig_err;
        wr(8, 32'hFF); wr(4, 32'h1234_5678);
        repeat (5) @(negedge clk);
        chk("R10 total held", 64'(total_size), 64'(held_t));
        chk("R10 flag held", 64'(contig_err), 64'(held_w));

        // Random configurations (R3, R4, R5, R8, R9)
        for (int t = 0; t < 40; t++) begin
            for (int i = 0; i < 8; i++) wr(i, $urandom);
            wr(8, $urandom);
            for (int b = 0; b < 8; b++) begin
                hit_at(exp_start(b), "R5 random start bound");
                hit_at(exp_end(b), "R5 random end bound");
                hit_at(exp_start(b) - 32'd1, "R5 random below start");
                hit_at(exp_end(b) + 32'd1, "R5 random above end");
            end
            hit_at($urandom, "R5 random address");
            if (t % 4 == 0) run_walk("random");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule